// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire management bus that configures external Ethernet PHYs. Software sets a clock divider, a frame-format bit and a preamble switch in a configuration register. It turns the block on through an enable register and places a 16-bit payload in the write-data register. A write to the command register then starts one serial frame on MDC/MDIO.

A single command register serves both Clause 22 and Clause 45 framing. The opcode field is decoded according to the current format bit. The command register also carries a 5-bit PHY address and a 5-bit register field, which holds the device address in Clause 45. Software learns that a frame has finished by polling a pending flag. The write-data register carries this flag for write and address frames, and the read-data register carries it for reads. The read-data register also returns the 16 captured bits and a valid flag.

Top module: `mdio_master`

## Requirements
- R1: After reset, both pending flags and the read valid flag read 0, `mdc_o` is low and `mdio_oe_o` is low (MDIO released).
- R2: An accepted command sets bit 31 (pending) of the write-data register for write and address frames, or bit 31 of the read-data register for read frames. The flag clears when the frame ends.
- R3: With the preamble bit set, the frame starts with 32 ones before the start field. With the bit clear, the frame starts directly at the start field.
- R4: Clause 22 format (mode bit 0) sends start bits 01. Opcode 0 is a write and goes out as 01; opcode 1 is a read and goes out as 10.
- R5: Clause 45 format (mode bit 1) sends start bits 00. Opcode 0 is an address frame sent as 00, opcode 1 is a write sent as 01, and opcode 3 is a read sent as 11.
- R6: After the opcode, the frame carries the 5-bit PHY address and then the 5-bit register/device field, both MSB first. For writes and address frames these are followed by turnaround bits 10 and the 16-bit write data, MSB first.
- R7: During a read frame, MDIO is released for both turnaround bits and the 16 data bits. The data is sampled MSB first into read-data bits [15:0], and bit 30 (valid) is set when the pending flag clears.
- R8: While a frame runs, each MDC phase lasts DIV+1 system clocks, where DIV is configuration bits [7:0]. MDIO changes only while MDC is low, and MDC stays low between frames.
- R9: A command written while either pending flag is set is ignored and starts no frame.
- R10: While enable bit 0 is clear, a command is ignored and no frame is generated.
- R11: Opcodes that have no meaning in the current format are ignored: 2 and 3 in Clause 22, and 2 in Clause 45.
- R12: The register map uses byte offsets 0x00 (configuration: [7:0] divider, [12] preamble, [24] mode), 0x08 (write data [15:0], pending [31]), 0x10 (read data [15:0], valid [30], pending [31]), 0x18 (command: [4:0] register/device, [12:8] PHY, [17:16] opcode) and 0x20 (enable [0]). Configuration and enable read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | 6 | Register byte offset |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data (combinational on address) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench records every bit at each MDC rise and compares whole frames, so several kinds of fault show up as bit mismatches. A design that reused one opcode table for both formats, or that dropped or doubled the preamble, would fail this comparison. So would a design that swapped the two address fields. Read frames are checked both for the release window and for the captured value with its valid flag. A decoder that sampled one bit early or shifted LSB first would return a visibly wrong word. Commands sent while a frame is in flight, while the block is disabled, or with an opcode that has no meaning in the current format must leave both pending flags clear and produce no MDC edges. A design that queued or accepted any of them would show a second frame or a stuck flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned FRAME_LEN = 32;
  localparam int unsigned PRE_LEN   = 32;

  localparam logic [5:0] OFF_CFG = 6'h00;
  localparam logic [5:0] OFF_WD  = 6'h08;
  localparam logic [5:0] OFF_RD  = 6'h10;
  localparam logic [5:0] OFF_CMD = 6'h18;
  localparam logic [5:0] OFF_EN  = 6'h20;

  localparam int unsigned CFG_PRE_BIT  = 12;
  localparam int unsigned CFG_MODE_BIT = 24;
  localparam int unsigned PEND_BIT     = 31;
  localparam int unsigned VALID_BIT    = 30;
  localparam int unsigned CMD_PHY_LSB  = 8;
  localparam int unsigned CMD_OP_LSB   = 16;

  typedef struct packed {
    logic                 ok;
    logic                 rd;
    logic [FRAME_LEN-1:0] word;
  } frame_req_t;

  function automatic frame_req_t build_frame(input logic c45, input logic [1:0] op,
                                             input logic [4:0] phy, input logic [4:0] rg,
                                             input logic [DATA_W-1:0] dat);
    frame_req_t r;
    logic [1:0] st, wop;
    r   = '0;
    st  = c45 ? 2'b00 : 2'b01;
    wop = 2'b00;
    r.ok = 1'b1;
    if (c45) begin
      case (op)
        2'd0: wop = 2'b00;
        2'd1: wop = 2'b01;
        2'd3: begin wop = 2'b11; r.rd = 1'b1; end
        default: r.ok = 1'b0;
      endcase
    end else begin
      case (op)
        2'd0: wop = 2'b01;
        2'd1: begin wop = 2'b10; r.rd = 1'b1; end
        default: r.ok = 1'b0;
      endcase
    end
    r.word = {st, wop, phy, rg, 2'b10, dat};
    return r;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned FRAME_LEN = 32,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DIV_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 rd_i,
  input  logic                 pre_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 mdio_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 mdc_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o
);
  localparam int unsigned POS_W   = $clog2(PRE_LEN + FRAME_LEN + 1);
  localparam int unsigned FI_W    = $clog2(FRAME_LEN);
  localparam int unsigned DAT_IDX = FRAME_LEN - DATA_W;
  localparam int unsigned TA_IDX  = DAT_IDX - 2;

  logic                 busy_q, rd_q, pre_q;
  logic [POS_W-1:0]     pos_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [DIV_W-1:0]     div_q;
  logic [DATA_W-1:0]    rsh_q;
  logic                 rise, fall;
  logic [POS_W-1:0]     pre_len, last_pos, fidx;
  logic [FI_W-1:0]      sel;
  logic                 in_pre, released, in_data;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .div_i (div_q),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign pre_len  = pre_q ? POS_W'(PRE_LEN) : '0;
  assign last_pos = pre_len + POS_W'(FRAME_LEN - 1);
  assign in_pre   = pos_q < pre_len;
  assign fidx     = pos_q - pre_len;
  assign sel      = FI_W'(FRAME_LEN - 1) - fidx[FI_W-1:0];
  assign released = rd_q && !in_pre && (fidx >= POS_W'(TA_IDX));
  assign in_data  = rd_q && !in_pre && (fidx >= POS_W'(DAT_IDX));

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall && (pos_q == last_pos);
  assign rdata_o   = rsh_q;
  assign mdio_o    = (!busy_q || in_pre) ? 1'b1 : frame_q[sel];
  assign mdio_oe_o = busy_q && !released;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      pre_q   <= 1'b0;
      pos_q   <= '0;
      frame_q <= '0;
      div_q   <= '0;
      rsh_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        rd_q    <= rd_i;
        pre_q   <= pre_i;
        div_q   <= div_i;
        frame_q <= frame_i;
        pos_q   <= '0;
      end
    end else begin
      if (rise && in_data) rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (pos_q == last_pos) busy_q <= 1'b0;
        else                   pos_q  <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              pre_q, mode_q, en_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              wr_pend_q, rd_pend_q, rd_valid_q;
  logic [1:0]        op_q;
  logic [4:0]        phy_q, rg_q;
  logic              hit_cmd, start, eng_busy, eng_done;
  logic [DATA_W-1:0] eng_rdata;
  frame_req_t        req;

  assign hit_cmd = csr_wr_i && (csr_addr_i == ADDR_W'(OFF_CMD));
  assign req     = build_frame(mode_q, csr_wdata_i[CMD_OP_LSB +: 2],
                               csr_wdata_i[CMD_PHY_LSB +: 5], csr_wdata_i[4:0], wdat_q);
  assign start   = hit_cmd && en_q && !wr_pend_q && !rd_pend_q && req.ok;

  mdio_frame_eng #(
    .PRE_LEN(PRE_LEN), .FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W), .DIV_W(DIV_W)
  ) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rd_i     (req.rd),
    .pre_i    (pre_q),
    .div_i    (div_q),
    .frame_i  (req.word),
    .mdio_i   (mdio_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .rdata_o  (eng_rdata),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q      <= '0;
      pre_q      <= 1'b0;
      mode_q     <= 1'b0;
      en_q       <= 1'b0;
      wdat_q     <= '0;
      rdat_q     <= '0;
      wr_pend_q  <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      op_q       <= '0;
      phy_q      <= '0;
      rg_q       <= '0;
    end else begin
      if (csr_wr_i) begin
        case (csr_addr_i)
          ADDR_W'(OFF_CFG): begin
            div_q  <= csr_wdata_i[DIV_W-1:0];
            pre_q  <= csr_wdata_i[CFG_PRE_BIT];
            mode_q <= csr_wdata_i[CFG_MODE_BIT];
          end
          ADDR_W'(OFF_WD): wdat_q <= csr_wdata_i[DATA_W-1:0];
          ADDR_W'(OFF_EN): en_q   <= csr_wdata_i[0];
          default: ;
        endcase
      end
      if (start) begin
        op_q  <= csr_wdata_i[CMD_OP_LSB +: 2];
        phy_q <= csr_wdata_i[CMD_PHY_LSB +: 5];
        rg_q  <= csr_wdata_i[4:0];
        if (req.rd) begin
          rd_pend_q  <= 1'b1;
          rd_valid_q <= 1'b0;
        end else begin
          wr_pend_q  <= 1'b1;
        end
      end
      if (eng_done) begin
        if (rd_pend_q) begin
          rd_pend_q  <= 1'b0;
          rd_valid_q <= 1'b1;
          rdat_q     <= eng_rdata;
        end
        wr_pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    case (csr_addr_i)
      ADDR_W'(OFF_CFG): begin
        csr_rdata_o[DIV_W-1:0]    = div_q;
        csr_rdata_o[CFG_PRE_BIT]  = pre_q;
        csr_rdata_o[CFG_MODE_BIT] = mode_q;
      end
      ADDR_W'(OFF_WD): begin
        csr_rdata_o[DATA_W-1:0] = wdat_q;
        csr_rdata_o[PEND_BIT]   = wr_pend_q;
      end
      ADDR_W'(OFF_RD): begin
        csr_rdata_o[DATA_W-1:0] = rdat_q;
        csr_rdata_o[VALID_BIT]  = rd_valid_q;
        csr_rdata_o[PEND_BIT]   = rd_pend_q;
      end
      ADDR_W'(OFF_CMD): begin
        csr_rdata_o[4:0]                = rg_q;
        csr_rdata_o[CMD_PHY_LSB +: 5]   = phy_q;
        csr_rdata_o[CMD_OP_LSB +: 2]    = op_q;
      end
      ADDR_W'(OFF_EN): csr_rdata_o[0] = en_q;
      default: ;
    endcase
  end

  logic unused_busy;
  assign unused_busy = eng_busy;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_wr_i,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              en_q,
  input logic              wr_pend_q,
  input logic              rd_pend_q,
  input logic              rd_valid_q
);
  logic cmd_wr;
  assign cmd_wr = csr_wr_i && (csr_addr_i == ADDR_W'(OFF_CMD));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_pend_q || rd_pend_q) |-> (!mdio_oe_o && !mdc_o));

  p_read_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_pend_q) |-> rd_valid_q);

  p_mdio_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> $stable(mdio_o));

  p_one_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_pend_q, rd_pend_q}));

  p_no_cmd_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_q && cmd_wr) |=> !wr_pend_q);

  p_no_cmd_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && cmd_wr && !wr_pend_q && !rd_pend_q) |=> (!wr_pend_q && !rd_pend_q));
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .csr_wr_i  (csr_wr_i),
  .csr_addr_i(csr_addr_i),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .en_q      (en_q),
  .wr_pend_q (wr_pend_q),
  .rd_pend_q (rd_pend_q),
  .rd_valid_q(rd_valid_q)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam logic [5:0] A_CFG = 6'h00, A_WD = 6'h08, A_RD = 6'h10, A_CMD = 6'h18, A_EN = 6'h20;

  typedef struct packed {
    logic        mode;
    logic        pre;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] rsp;
    logic [7:0]  div;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'd0, 5'h01, 5'h02, 16'hA5C3, 16'h0000, 8'd1},
    '{1'b0, 1'b1, 2'd1, 5'h1F, 5'h00, 16'h0000, 16'h8001, 8'd0},
    '{1'b1, 1'b1, 2'd0, 5'h03, 5'h05, 16'h1234, 16'h0000, 8'd2},
    '{1'b1, 1'b0, 2'd1, 5'h10, 5'h1E, 16'hFFFF, 16'h0000, 8'd0},
    '{1'b1, 1'b1, 2'd3, 5'h0A, 5'h07, 16'h0000, 16'h5AA5, 8'd1},
    '{1'b0, 1'b0, 2'd1, 5'h15, 5'h11, 16'h0000, 16'h0FF0, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_wr = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_chk = 0, n_bad = 0;
  logic cap_b [64];
  logic cap_oe [64];
  int   ncap = 0, plen = 0, last_hi = 0, hi_cnt = 0, viol = 0;
  logic rsp_on = 1'b0;
  logic [15:0] rsp_val = '0;
  logic mdc_prev = 1'b0, mdio_prev = 1'b1;

  always #5 clk = ~clk;

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .csr_wr_i(csr_wr), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // bus monitor and PHY responder
  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      if (ncap < 64) begin
        cap_b[ncap]  = mdio_out;
        cap_oe[ncap] = mdio_oe;
      end
      ncap   = ncap + 1;
      hi_cnt = 0;
    end
    if (mdc && mdc_prev && mdio_oe && (mdio_out !== mdio_prev)) viol = viol + 1;
    if (mdc) hi_cnt = hi_cnt + 1;
    if (!mdc && mdc_prev) begin
      last_hi = hi_cnt;
      if (rsp_on && (ncap - plen) >= 16 && (ncap - plen) < 32)
        mdio_in = rsp_val[31 - (ncap - plen)];
      else
        mdio_in = 1'b1;
    end
    mdc_prev  = mdc;
    mdio_prev = mdio_out;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  function automatic logic [31:0] exp_word(input vec_t v);
    logic [1:0] st, wop;
    st  = v.mode ? 2'b00 : 2'b01;
    if (v.mode) wop = (v.op == 2'd0) ? 2'b00 : (v.op == 2'd1) ? 2'b01 : 2'b11;
    else        wop = (v.op == 2'd0) ? 2'b01 : 2'b10;
    return {st, wop, v.phy, v.rg, 2'b10, v.wd};
  endfunction

  function automatic logic is_read(input vec_t v);
    return v.mode ? (v.op == 2'd3) : (v.op == 2'd1);
  endfunction

  function automatic logic [31:0] cmd_of(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
    return (32'(op) << 16) | (32'(phy) << 8) | 32'(rg);
  endfunction

  task automatic wait_idle(input logic [5:0] a, input string tag);
    logic [31:0] d;
    int n;
    n = 0;
    rd(a, d);
    while (d[31] && n < 20000) begin
      rd(a, d);
      n++;
    end
    chk(tag, {31'b0, d[31]}, 32'd0);
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] d, w;
    logic        r;
    int          bad_b, bad_oe, idx;
    string       ftag;
    r    = is_read(v);
    w    = exp_word(v);
    ftag = v.mode ? "R5" : "R4";
    wr(A_CFG, {7'b0, v.mode, 11'b0, v.pre, 4'b0, v.div});
    wr(A_WD, {16'b0, v.wd});
    ncap = 0; plen = v.pre ? 32 : 0; rsp_on = r; rsp_val = v.rsp; viol = 0;
    wr(A_CMD, cmd_of(v.op, v.phy, v.rg));
    rd(r ? A_RD : A_WD, d);
    chk("R2 pending set", {31'b0, d[31]}, 32'd1);
    wait_idle(r ? A_RD : A_WD, "R2 pending cleared");
    chk("R3 bit count", 32'(ncap), 32'(plen + 32));
    bad_b = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < plen + 32) begin
        idx = i - plen;
        if (i < plen) begin
          if (cap_b[i] !== 1'b1 || cap_oe[i] !== 1'b1) bad_b++;
        end else begin
          if (!(r && idx >= 14) && cap_b[i] !== w[31 - idx]) bad_b++;
          if (cap_oe[i] !== !(r && idx >= 14)) bad_oe++;
        end
      end
    end
    chk({ftag, " R3 R6 frame bits"}, 32'(bad_b), 32'd0);
    chk("R7 R6 drive/release pattern", 32'(bad_oe), 32'd0);
    chk("R8 mdc half period", 32'(last_hi), 32'(v.div) + 32'd1);
    chk("R8 mdio moved while mdc high", 32'(viol), 32'd0);
    chk("R8 mdc low when idle", {31'b0, mdc}, 32'd0);
    if (r) begin
      rd(A_RD, d);
      chk("R7 read data and valid", d, {2'b01, 14'b0, v.rsp});
    end
    rsp_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(A_WD, d);
    chk("R1 write pending at reset", d, 32'd0);
    rd(A_RD, d);
    chk("R1 read pending/valid at reset", d, 32'd0);
    chk("R1 mdc/oe at reset", {30'b0, mdc, mdio_oe}, 32'd0);
    @(negedge clk) rst_ni = 1'b1;

    wr(A_CFG, 32'h0100_1005);
    rd(A_CFG, d);
    chk("R12 config readback", d, 32'h0100_1005);
    wr(A_EN, 32'd1);
    rd(A_EN, d);
    chk("R12 enable readback", d, 32'd1);

    for (int v = 0; v < NV; v++) run_vec(VEC[v]);

    // R9: command during a running write frame is dropped
    wr(A_CFG, {7'b0, 1'b0, 11'b0, 1'b1, 4'b0, 8'd3});
    wr(A_WD, 32'h0000_1111);
    ncap = 0; plen = 32;
    wr(A_CMD, cmd_of(2'd0, 5'h01, 5'h01));
    repeat (20) @(negedge clk);
    wr(A_CMD, cmd_of(2'd1, 5'h02, 5'h02));
    rd(A_RD, d);
    chk("R9 read not started while busy", {31'b0, d[31]}, 32'd0);
    rd(A_WD, d);
    chk("R9 write still pending", {31'b0, d[31]}, 32'd1);
    wait_idle(A_WD, "R9 write completes");
    repeat (300) @(negedge clk);
    chk("R9 single frame only", 32'(ncap), 32'd64);

    // R10: disabled block ignores commands
    wr(A_EN, 32'd0);
    ncap = 0;
    wr(A_CMD, cmd_of(2'd1, 5'h04, 5'h04));
    repeat (200) @(negedge clk);
    rd(A_RD, d);
    chk("R10 no pending when disabled", {31'b0, d[31]}, 32'd0);
    chk("R10 no mdc activity when disabled", 32'(ncap), 32'd0);
    wr(A_EN, 32'd1);

    // R11: undefined opcodes are ignored
    wr(A_CFG, {7'b0, 1'b1, 11'b0, 1'b1, 4'b0, 8'd0});
    ncap = 0;
    wr(A_CMD, cmd_of(2'd2, 5'h01, 5'h01));
    repeat (200) @(negedge clk);
    rd(A_WD, d);
    chk("R11 clause45 op2 write pending", {31'b0, d[31]}, 32'd0);
    rd(A_RD, d);
    chk("R11 clause45 op2 read pending", {31'b0, d[31]}, 32'd0);
    wr(A_CFG, {7'b0, 1'b0, 11'b0, 1'b1, 4'b0, 8'd0});
    wr(A_CMD, cmd_of(2'd3, 5'h01, 5'h01));
    repeat (200) @(negedge clk);
    rd(A_WD, d);
    chk("R11 clause22 op3 write pending", {31'b0, d[31]}, 32'd0);
    rd(A_RD, d);
    chk("R11 clause22 op3 read pending", {31'b0, d[31]}, 32'd0);
    chk("R11 no frame for bad opcodes", 32'(ncap), 32'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule